// File: doc/BRIEF.md
# Three-Channel Sampled Glitch Filter

This block cleans up three asynchronous digital inputs before they reach position-counting logic: two quadrature phase signals and one index signal. Each raw input first passes through a two-flop synchronizer. A shared divider derives a sample strobe from the system clock. Each channel's output takes a new level only after the synchronized input has shown that level on three strobes in a row, so spikes shorter than that never get through.

A single enable picks what downstream logic sees. When the enable is high, it sees the qualified outputs. When the enable is low, it sees the synchronized raw signals. The enable is expected to be low after reset. While the filter is bypassed, its internal state keeps reloading from the live input. Turning the enable on therefore starts from the present input level rather than a stale one. Channel order on the vectors is: bit 0 is phase A, bit 1 is phase B, bit 2 is the index.

Top module: `qgf_filter_top`

## Requirements
- R1: While reset is active and after reset release, with the enable low and the inputs low, every output bit is 0.
- R2: The 3-bit divider select sets the strobe period in system clocks: code 0→1, 1→2, 2→4, 3→16, 4→32, 5→64, 6→128, 7→256. The divider stays at its start point while the enable is low. Its first strobe comes on the R-th clock after the enable rises, and one comes every R clocks after that.
- R3: With the enable high, an output bit can change only on the clock edge that carries a strobe.
- R4: With the enable high, an output bit takes a new level on the third consecutive strobe at which its synchronized input shows that level.
- R5: A level on a synchronized input that lasts for fewer than three consecutive strobes never reaches the output.
- R6: With the enable low, each output bit equals its raw input delayed by exactly two clocks.
- R7: While the enable is low, each channel's filter state reloads from its synchronized input. After the enable rises, the output holds the level the synchronized input had in the last bypassed cycle until three strobes qualify a new one.
- R8: All three channels use the same strobe. Each channel qualifies its own input independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; internally released on the clock |
| raw_i | input | 3 | Raw asynchronous inputs: bit 0 phase A, bit 1 phase B, bit 2 index |
| div_sel_i | input | 3 | Sample strobe divider select code |
| filt_en_i | input | 1 | 1: qualified outputs; 0: synchronized raw inputs |
| sig_o | output | 3 | Channel outputs, same bit order as raw_i |

## Verification
The strobe-spacing property assumes that the divider select is held steady across a strobe interval. It is checked only over intervals in which the select did not move, because a mid-interval change can end the interval early. The bypass-delay property assumes that the enable is treated as a quasi-static control, and it is compared only once the synchronizer has filled after the internal reset lifts. The stimulus changes the select and the enable only at segment boundaries, with each segment hundreds of clocks long. The noise pulses on the raw inputs are sized relative to the active divide ratio, so pulses both shorter and longer than three strobes occur.

// File: rtl/qgf_pkg.sv
package qgf_pkg;

  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MAX_SHIFT = 8;
  localparam int unsigned DIV_CNT_W = MAX_SHIFT + 1;

  typedef logic [SEL_W-1:0]     div_sel_t;
  typedef logic [DIV_CNT_W-1:0] div_cnt_t;

  // codes 0..2 give 2^code, codes 3..7 skip 8 and give 2^(code+1)
  function automatic div_cnt_t period_last(input div_sel_t sel);
    div_cnt_t one;
    int unsigned sh;
    one = div_cnt_t'(1);
    sh  = (sel < div_sel_t'(3)) ? int'(sel) : int'(sel) + 1;
    return (one << sh) - one;
  endfunction

endpackage

// File: rtl/qgf_rst_sync.sv
module qgf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/qgf_sync.sv
module qgf_sync #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] q_o
);

  logic [NCH-1:0] meta_q;
  logic [NCH-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/qgf_strobe_gen.sv
module qgf_strobe_gen
  import qgf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  div_sel_t sel_i,
  output logic     strobe_o
);

  div_cnt_t cnt_q;
  div_cnt_t cnt_d;
  div_cnt_t last_w;
  logic     hit_w;

  always_comb begin
    last_w = period_last(sel_i);
    // >= rather than == so a select change to a shorter period cannot overrun
    hit_w  = run_i && (cnt_q >= last_w);
    if (!run_i || hit_w) cnt_d = '0;
    else                 cnt_d = cnt_q + div_cnt_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign strobe_o = hit_w;

endmodule

// File: rtl/qgf_chan.sv
module qgf_chan #(
  parameter int unsigned AGREE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic d_i,
  output logic q_o
);

  localparam int unsigned HIST_W = AGREE - 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic              filt_q;
  logic              filt_d;
  logic              agree_w;
  logic              load_en;

  always_comb begin
    agree_w = (hist_q == {HIST_W{d_i}});
    load_en = !en_i || strobe_i;
    hist_d  = hist_q;
    filt_d  = filt_q;
    if (!en_i) begin
      hist_d = {HIST_W{d_i}};
      filt_d = d_i;
    end else if (strobe_i) begin
      if (HIST_W > 1) hist_d = {hist_q[HIST_W-2:0], d_i};
      else            hist_d = d_i;
      if (agree_w) filt_d = d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else if (load_en) begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign q_o = filt_q;

endmodule

// File: rtl/qgf_filter_top.sv
module qgf_filter_top
  import qgf_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned AGREE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   raw_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             filt_en_i,
  output logic [NCH-1:0]   sig_o
);

  logic           rst_int_n;
  logic [NCH-1:0] sync_w;
  logic [NCH-1:0] filt_w;
  logic           strobe_w;

  qgf_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  qgf_sync #(.NCH(NCH)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    (raw_i),
    .q_o    (sync_w)
  );

  qgf_strobe_gen strobe_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .run_i    (filt_en_i),
    .sel_i    (div_sel_t'(div_sel_i)),
    .strobe_o (strobe_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    qgf_chan #(.AGREE(AGREE)) chan_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_int_n),
      .en_i     (filt_en_i),
      .strobe_i (strobe_w),
      .d_i      (sync_w[ch]),
      .q_o      (filt_w[ch])
    );
  end

  assign sig_o = filt_en_i ? filt_w : sync_w;

endmodule

// File: rtl/qgf_filter_chk.sv
module qgf_filter_chk #(
  parameter int unsigned NCH = 3
) (
  input logic           clk_i,
  input logic           rst_int_ni,
  input logic [NCH-1:0] raw_i,
  input logic [2:0]     div_sel_i,
  input logic           filt_en_i,
  input logic [NCH-1:0] sig_o,
  input logic [NCH-1:0] sync_i,
  input logic           strobe_i
);

  logic [1:0] warm_q;
  logic [8:0] gap_q;
  logic [2:0] sel_q;
  logic       clean_q;
  logic       clean_now;
  logic [8:0] exp_last;

  always_comb begin
    clean_now = clean_q && (div_sel_i == sel_q);
    case (div_sel_i)
      3'd0: exp_last = 9'd0;
      3'd1: exp_last = 9'd1;
      3'd2: exp_last = 9'd3;
      3'd3: exp_last = 9'd15;
      3'd4: exp_last = 9'd31;
      3'd5: exp_last = 9'd63;
      3'd6: exp_last = 9'd127;
      default: exp_last = 9'd255;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_int_ni) begin
    if (!rst_int_ni) begin
      warm_q  <= '0;
      gap_q   <= '0;
      sel_q   <= '0;
      clean_q <= 1'b0;
    end else begin
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      sel_q <= div_sel_i;
      if (!filt_en_i || strobe_i) begin
        gap_q   <= '0;
        clean_q <= 1'b1;
      end else begin
        gap_q   <= gap_q + 9'd1;
        clean_q <= clean_now;
      end
    end
  end

  a_r2_strobe_period: assert property (@(posedge clk_i) disable iff (!rst_int_ni)
    (strobe_i && clean_now && warm_q != 2'd0) |-> (gap_q == exp_last));

  a_r2_no_strobe_when_off: assert property (@(posedge clk_i) disable iff (!rst_int_ni)
    strobe_i |-> filt_en_i);

  a_r3_change_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_int_ni)
    (warm_q != 2'd0 && filt_en_i && $past(filt_en_i) && sig_o != $past(sig_o))
      |-> $past(strobe_i));

  a_r5_change_matches_input: assert property (@(posedge clk_i) disable iff (!rst_int_ni)
    (warm_q != 2'd0 && filt_en_i && $past(filt_en_i) && sig_o != $past(sig_o))
      |-> (((sig_o ^ $past(sig_o)) & (sig_o ^ $past(sync_i))) == '0));

  a_r6_bypass_delay: assert property (@(posedge clk_i) disable iff (!rst_int_ni)
    (!filt_en_i && warm_q >= 2'd2) |-> (sig_o == $past(raw_i, 2)));

endmodule

bind qgf_filter_top qgf_filter_chk #(.NCH(NCH)) chk_i (
  .clk_i      (clk_i),
  .rst_int_ni (rst_int_n),
  .raw_i      (raw_i),
  .div_sel_i  (div_sel_i),
  .filt_en_i  (filt_en_i),
  .sig_o      (sig_o),
  .sync_i     (sync_w),
  .strobe_i   (strobe_w)
);

// File: tb/qgf_filter_top_tb_top.sv
module qgf_filter_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic [2:0] raw;
  logic [2:0] sel;
  logic       en;
  logic [2:0] sig;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  qgf_filter_top dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .raw_i     (raw),
    .div_sel_i (sel),
    .filt_en_i (en),
    .sig_o     (sig)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd0: return 1;   3'd1: return 2;   3'd2: return 4;   3'd3: return 16;
      3'd4: return 32;  3'd5: return 64;  3'd6: return 128; default: return 256;
    endcase
  endfunction

  // reference model built from the requirements
  logic       rs1, rs2;
  logic [2:0] m1, m2, mf, mlast;
  int         mc;
  int         run [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; m1 = 0; m2 = 0; mf = 0; mlast = 0; mc = 0;
      for (int c = 0; c < 3; c++) run[c] = 3;
    end else begin
      logic rs_pre, stb;
      rs_pre = rs2; rs2 = rs1; rs1 = 1;
      if (rs_pre) begin
        stb = en && (mc >= ratio(sel) - 1);
        for (int c = 0; c < 3; c++) begin
          if (!en) begin
            mlast[c] = m2[c]; run[c] = 3; mf[c] = m2[c];
          end else if (stb) begin
            if (m2[c] == mlast[c]) run[c] = (run[c] >= 3) ? 3 : run[c] + 1;
            else run[c] = 1;
            mlast[c] = m2[c];
            if (run[c] >= 3) mf[c] = m2[c];
          end
        end
        mc = (!en || stb) ? 0 : mc + 1;
        m2 = m1; m1 = raw;
      end
    end
  end

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock, then compare against the model away from the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (en) chk("R3 R4 R5 R8 model", sig, mf);
    else    chk("R6 model", sig, m2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    int n;
    logic [2:0] basev;
    int plen [3];
    seed_v = $urandom(32'd20260611);
    raw = 0; sel = 0; en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", sig, 3'b000);
    rst_n = 1;
    repeat (5) step();
    chk("R1 after release", sig, 3'b000);

    // R6: bypass delay of exactly two clocks
    raw = 3'b101;
    step(); chk("R6 one clock", sig, 3'b000);
    step(); chk("R6 two clocks", sig, 3'b101);
    raw = 3'b000; repeat (4) step();

    // R2 / R7: latency from enable to qualified output for every code
    for (int s = 0; s < 8; s++) begin
      int r, e;
      sel = 3'(s); en = 0; raw = 0;
      repeat (6) step();
      en = 1; raw = 3'b111;
      r = ratio(3'(s));
      e = (r == 1) ? 5 : (r == 2) ? 8 : 3 * r;
      n = 0;
      do begin step(); n++; end while (sig != 3'b111 && n < 1000);
      checks++;
      if (n != e) begin
        errors++;
        $display("FAIL R2 R7 sel=%0d actual=%0d expected=%0d", s, n, e);
      end
    end

    // R5: two-strobe pulse blocked; R4: three-strobe pulse passes
    sel = 0; en = 0; raw = 0; repeat (4) step();
    en = 1; repeat (6) step();
    raw = 3'b111; repeat (2) step(); raw = 0;
    begin
      logic [2:0] seen;
      seen = 0;
      repeat (10) begin step(); seen |= sig; end
      chk("R5 short pulse blocked", seen, 3'b000);
    end
    raw = 3'b010; repeat (3) step(); raw = 0;
    begin
      logic [2:0] seen;
      seen = 0;
      repeat (10) begin step(); seen |= sig; end
      chk("R4 R8 three-strobe pulse passes", seen, 3'b010);
    end

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      int r;
      sel = (seg % 10 == 9) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
      en  = ($urandom_range(0, 4) != 0);
      r   = ratio(sel);
      basev = raw;
      for (int c = 0; c < 3; c++) plen[c] = 0;
      for (int k = 0; k < 600; k++) begin
        logic [2:0] v;
        for (int c = 0; c < 3; c++) begin
          if ($urandom_range(0, 8 * r) == 0) basev[c] = ~basev[c];
          if (plen[c] > 0) plen[c]--;
          else if ($urandom_range(0, 10) == 0) plen[c] = $urandom_range(1, 4 * r);
          v[c] = (plen[c] > 0) ? ~basev[c] : basev[c];
        end
        raw = v;
        step();
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule